// File: doc/BRIEF.md
# Interrupt and DMA Request Controller

This block sits beside a data acquisition core and collects eight single-cycle event pulses into a sticky status register. A host reads that register through a one-cycle read strobe. The read returns the pending bits and clears them in the same access. A separate enable register holds a per-source enable mask and a threshold for the result FIFO. The active-low interrupt line is driven whenever a pending bit has its enable bit set.

The same block watches the occupancy count of the conversion result FIFO. It raises a DMA request once the count lands exactly on the programmed threshold. The request stays up until the FIFO has drained to empty. The FIFO and the event sources are outside this block.

Two state machines carry the outputs. The interrupt line machine has the states IRQ_IDLE and IRQ_RAISED. Its transition IRQ_IDLE to IRQ_RAISED ("raise") is taken when the next-cycle status, masked by the next-cycle enables, is non-zero. Its transition IRQ_RAISED to IRQ_IDLE ("release") is taken when that masked value becomes zero, through a read or an enable write. The DMA machine has the states DMA_IDLE and DMA_REQ. Its transition DMA_IDLE to DMA_REQ ("hit") is taken when the FIFO count is non-zero and equals the threshold. Its transition DMA_REQ to DMA_IDLE ("drain") is taken when the count is zero. In every other case a machine stays in its state.

Top module: `irq_dma_ctrl`

## Requirements
- R1: `irq_n_o` is low exactly when `stat_o` has at least one bit set whose enable bit is 1. The line changes at the same clock edge as the status and enable registers.
- R2: An `evt_i[k]` pulse sets `stat_o[k]` at the next clock edge, whatever the enable bit k holds. Without a read, a set bit stays set.
- R3: While `stat_rd_i` is high, `stat_o` shows the status before the clear. After that edge every bit is zero, except the bits covered by R4.
- R4: An event that arrives in the same cycle as `stat_rd_i` leaves its status bit set after the clear.
- R5: With `en_wr_i` high, the next edge loads `en_mask_i` into the enable mask (bit k = 1 enables source k) and loads `en_thr_i` into the DMA threshold. A mask change alters `irq_n_o` from that same edge.
- R6: `dma_req_o` rises at the edge that follows a cycle in which `fifo_count_i` is non-zero and equals the stored threshold.
- R7: Once high, `dma_req_o` stays high while `fifo_count_i` is non-zero, even when the count moves above or below the threshold. It falls at the edge that follows a cycle with `fifo_count_i` equal to 0.
- R8: A count that steps past the threshold without ever equalling it does not raise `dma_req_o`. A threshold of 0 never raises it.
- R9: Reset clears `stat_o`, drives `irq_n_o` high and `dma_req_o` low, sets the enable mask to 0 (all sources masked) and sets the threshold to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_SRC | Single-cycle event pulses, one per source |
| stat_rd_i | input | 1 | Status read strobe, clears status after this cycle |
| en_wr_i | input | 1 | Enable register write strobe |
| en_mask_i | input | N_SRC | New enable mask, bit = 1 enables source |
| en_thr_i | input | CNT_W | New DMA threshold |
| fifo_count_i | input | CNT_W | Result FIFO occupancy |
| stat_o | output | N_SRC | Pending status bits |
| irq_n_o | output | 1 | Active-low interrupt line |
| dma_req_o | output | 1 | Active-high DMA request |

## Verification
The checker tests on every cycle that the interrupt line matches the masked status. It also checks that events are captured and held, that a read clears everything except same-cycle events, and that the DMA request rises, holds and drains only under its stated count conditions. The bench scenarios are needed to show the remaining behaviour. These include the pre-clear value seen during a read, masked events staying invisible on the line until an enable write, and the reset state. They also cover a count that skips over the threshold and the zero-threshold case, which need specific count sequences.

// File: rtl/irq_dma_pkg.sv
package irq_dma_pkg;
    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;

    typedef enum logic [0:0] {
        DMA_IDLE = 1'b0,
        DMA_REQ  = 1'b1
    } dma_state_t;
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int N_SRC = 8,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [N_SRC-1:0] mask_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic [N_SRC-1:0] mask_q_o,
    output logic [N_SRC-1:0] mask_nxt_o,
    output logic [CNT_W-1:0] thr_q_o
);
    logic [N_SRC-1:0] mask_q;
    logic [CNT_W-1:0] thr_q;

    always_comb mask_nxt_o = wr_i ? mask_i : mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            thr_q  <= '0;
        end else if (wr_i) begin
            mask_q <= mask_i;
            thr_q  <= thr_i;
        end
    end

    assign mask_q_o = mask_q;
    assign thr_q_o  = thr_q;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             clr_i,
    output logic [N_SRC-1:0] st_q_o,
    output logic [N_SRC-1:0] st_nxt_o
);
    logic [N_SRC-1:0] st_q;
    logic [N_SRC-1:0] st_nxt;

    // Each bit: cleared by a read, but a same-cycle event wins.
    for (genvar k = 0; k < N_SRC; k++) begin : g_bit
        always_comb st_nxt[k] = (st_q[k] & ~clr_i) | evt_i[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_nxt;
    end

    assign st_q_o   = st_q;
    assign st_nxt_o = st_nxt;
endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_nxt_i,
    output logic irq_n_o
);
    irq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pend_nxt_i)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pend_nxt_i) state_d = IRQ_IDLE;
        endcase
    end

    always_comb irq_n_o = (state_q != IRQ_RAISED);
endmodule

// File: rtl/dma_req_fsm.sv
module dma_req_fsm
    import irq_dma_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             req_o
);
    dma_state_t state_q, state_d;
    logic empty;
    logic hit;

    always_comb begin
        empty = (count_i == '0);
        hit   = !empty && (count_i == thr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DMA_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DMA_IDLE: if (hit)   state_d = DMA_REQ;
            DMA_REQ:  if (empty) state_d = DMA_IDLE;
        endcase
    end

    always_comb req_o = (state_q == DMA_REQ);
endmodule

// File: rtl/irq_dma_ctrl.sv
module irq_dma_ctrl #(
    parameter int N_SRC      = 8,
    parameter int FIFO_DEPTH = 32,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             stat_rd_i,
    input  logic             en_wr_i,
    input  logic [N_SRC-1:0] en_mask_i,
    input  logic [CNT_W-1:0] en_thr_i,
    input  logic [CNT_W-1:0] fifo_count_i,
    output logic [N_SRC-1:0] stat_o,
    output logic             irq_n_o,
    output logic             dma_req_o
);
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] mask_nxt;
    logic [CNT_W-1:0] thr_q;
    logic [N_SRC-1:0] st_q;
    logic [N_SRC-1:0] st_nxt;
    logic             pend_nxt;

    irq_enable_reg #(.N_SRC(N_SRC), .CNT_W(CNT_W)) u_en (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (en_wr_i),
        .mask_i     (en_mask_i),
        .thr_i      (en_thr_i),
        .mask_q_o   (mask_q),
        .mask_nxt_o (mask_nxt),
        .thr_q_o    (thr_q)
    );

    irq_status_reg #(.N_SRC(N_SRC)) u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_i    (stat_rd_i),
        .st_q_o   (st_q),
        .st_nxt_o (st_nxt)
    );

    always_comb pend_nxt = |(st_nxt & mask_nxt);

    irq_line_fsm u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_nxt_i (pend_nxt),
        .irq_n_o    (irq_n_o)
    );

    dma_req_fsm #(.CNT_W(CNT_W)) u_dma (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_i (fifo_count_i),
        .thr_i   (thr_q),
        .req_o   (dma_req_o)
    );

    assign stat_o = st_q;
endmodule

// File: rtl/irq_dma_chk.sv
module irq_dma_chk #(
    parameter int N_SRC = 8,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] evt_i,
    input logic             stat_rd_i,
    input logic [CNT_W-1:0] fifo_count_i,
    input logic [N_SRC-1:0] stat_o,
    input logic             irq_n_o,
    input logic             dma_req_o,
    input logic [N_SRC-1:0] mask_q,
    input logic [CNT_W-1:0] thr_q
);
    p_irq_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n_o == !(|(stat_o & mask_q)));

    p_evt_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((stat_o & $past(evt_i)) == $past(evt_i)));

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

    // R3 and R4: after a read only same-cycle events remain
    p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_i |=> ((stat_o & ~$past(evt_i)) == '0));

    p_dma_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count_i != '0 && fifo_count_i == thr_q) |=> dma_req_o);

    p_dma_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_o && fifo_count_i != '0) |=> dma_req_o);

    p_dma_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count_i == '0) |=> !dma_req_o);

    p_dma_no_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req_o && fifo_count_i != thr_q) |=> !dma_req_o);
endmodule

bind irq_dma_ctrl irq_dma_chk #(.N_SRC(N_SRC), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt_i),
    .stat_rd_i    (stat_rd_i),
    .fifo_count_i (fifo_count_i),
    .stat_o       (stat_o),
    .irq_n_o      (irq_n_o),
    .dma_req_o    (dma_req_o),
    .mask_q       (mask_q),
    .thr_q        (thr_q)
);

// File: tb/test_irq_dma_ctrl.sv
`timescale 1ns/1ps
module test_irq_dma_ctrl;
    localparam int N_SRC = 8;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_SRC-1:0] evt_i = '0;
    logic             stat_rd_i = 1'b0;
    logic             en_wr_i = 1'b0;
    logic [N_SRC-1:0] en_mask_i = '0;
    logic [CNT_W-1:0] en_thr_i = '0;
    logic [CNT_W-1:0] fifo_count_i = '0;
    logic [N_SRC-1:0] stat_o;
    logic             irq_n_o;
    logic             dma_req_o;

    int checks = 0;
    int failures = 0;

    // reference model state
    logic [N_SRC-1:0] m_stat = '0;
    logic [N_SRC-1:0] m_mask = '0;
    logic [CNT_W-1:0] m_thr = '0;
    logic             m_dma = 1'b0;

    // scoreboard queues
    logic [N_SRC-1:0] q_stat[$];
    logic             q_irqn[$];
    logic             q_dma[$];
    string            q_tag[$];

    always #4 clk = ~clk;

    irq_dma_ctrl #(.N_SRC(N_SRC), .CNT_W(CNT_W)) i_irq_dma_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt_i),
        .stat_rd_i    (stat_rd_i),
        .en_wr_i      (en_wr_i),
        .en_mask_i    (en_mask_i),
        .en_thr_i     (en_thr_i),
        .fifo_count_i (fifo_count_i),
        .stat_o       (stat_o),
        .irq_n_o      (irq_n_o),
        .dma_req_o    (dma_req_o)
    );

    task automatic check(input string tag, input logic [N_SRC-1:0] a_st, input logic a_irqn,
                         input logic a_dma, input logic [N_SRC-1:0] e_st, input logic e_irqn,
                         input logic e_dma);
        checks++;
        if (a_st !== e_st || a_irqn !== e_irqn || a_dma !== e_dma) begin
            failures++;
            $display("FAIL %s: stat=%h irq_n=%b dma=%b expected stat=%h irq_n=%b dma=%b",
                     tag, a_st, a_irqn, a_dma, e_st, e_irqn, e_dma);
        end
    endtask

    // driver: one cycle of stimulus, expected post-edge outputs pushed
    task automatic step(input logic [N_SRC-1:0] evt, input logic rd, input logic wr,
                        input logic [N_SRC-1:0] msk, input logic [CNT_W-1:0] thr,
                        input logic [CNT_W-1:0] cnt, input string tag);
        logic [N_SRC-1:0] n_stat;
        logic [N_SRC-1:0] n_mask;
        logic [CNT_W-1:0] n_thr;
        logic             n_dma;
        @(negedge clk);
        evt_i = evt; stat_rd_i = rd; en_wr_i = wr;
        en_mask_i = msk; en_thr_i = thr; fifo_count_i = cnt;
        if (rd) begin
            // R3: value visible during the read is the pre-clear status
            checks++;
            if (stat_o !== m_stat) begin
                failures++;
                $display("FAIL R3 %s: read value=%h expected=%h", tag, stat_o, m_stat);
            end
        end
        n_stat = (rd ? '0 : m_stat) | evt;
        n_mask = wr ? msk : m_mask;
        n_thr  = wr ? thr : m_thr;
        if (m_dma) n_dma = (cnt != '0);
        else       n_dma = (cnt != '0) && (cnt == m_thr);
        m_stat = n_stat; m_mask = n_mask; m_thr = n_thr; m_dma = n_dma;
        q_stat.push_back(n_stat);
        q_irqn.push_back(!(|(n_stat & n_mask)));
        q_dma.push_back(n_dma);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input logic [CNT_W-1:0] cnt, input string tag);
        step('0, 1'b0, 1'b0, '0, '0, cnt, tag);
    endtask

    // monitor: compares after each edge
    always @(posedge clk) begin
        #2;
        if (q_tag.size() > 0) begin
            check(q_tag.pop_front(), stat_o, irq_n_o, dma_req_o,
                  q_stat.pop_front(), q_irqn.pop_front(), q_dma.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset", stat_o, irq_n_o, dma_req_o, '0, 1'b1, 1'b0);
        rst_n = 1'b1;

        // R9/R2: events recorded while all sources masked, line stays high
        step(8'h01, 0, 0, '0, '0, '0, "R2 masked event");
        step(8'h80, 0, 0, '0, '0, '0, "R9 masked after reset");
        idle('0, "R2 sticky hold");
        // R5/R1: enable source 0, line falls at the write edge
        step('0, 0, 1, 8'h01, '0, '0, "R5 mask write");
        idle('0, "R1 line held");
        // R3: read clears everything, line releases
        step('0, 1, 0, '0, '0, '0, "R3 read clear");
        idle('0, "R3 cleared stays");
        // R1: mixed events with partial mask
        step('0, 0, 1, 8'h0F, '0, '0, "R5 mask 0F");
        step(8'hA0, 0, 0, '0, '0, '0, "R1 only masked bits");
        step(8'h05, 0, 0, '0, '0, '0, "R1 enabled bits");
        // R4: event in the read cycle survives (bit 6 disabled)
        step(8'h40, 1, 0, '0, '0, '0, "R4 same-cycle event");
        idle('0, "R4 hold");
        // R4: enabled event in read cycle keeps the line low
        step(8'h02, 1, 0, '0, '0, '0, "R4 enabled same-cycle");
        // R5: disabling all sources releases line with status kept
        step('0, 0, 1, 8'h00, '0, '0, "R5 mask clear");
        step('0, 0, 1, 8'hFF, 6'd4, '0, "R5 mask all, thr 4");
        step('0, 1, 0, '0, '0, '0, "R3 read clear 2");

        // DMA: R6 rise on exact match, R7 hold and drain
        idle(6'd1, "R6 below thr");
        idle(6'd2, "R6 below thr");
        idle(6'd3, "R6 below thr");
        idle(6'd4, "R6 match");
        idle(6'd5, "R7 above thr");
        idle(6'd9, "R7 above thr");
        idle(6'd2, "R7 below thr");
        idle(6'd1, "R7 one left");
        idle(6'd0, "R7 empty drain");
        idle(6'd0, "R7 stays low");
        // R8: skip over threshold
        idle(6'd2, "R8 before skip");
        idle(6'd6, "R8 skipped");
        idle(6'd3, "R8 after skip");
        idle(6'd0, "R8 empty");
        // R8: threshold 0 never raises
        step('0, 0, 1, 8'hFF, 6'd0, 6'd0, "R8 thr zero write");
        idle(6'd0, "R8 thr zero");
        idle(6'd1, "R8 thr zero count 1");
        idle(6'd0, "R8 thr zero back");
        // R6: threshold at maximum count
        step('0, 0, 1, 8'hFF, 6'd32, 6'd31, "R6 thr max write");
        idle(6'd32, "R6 max match");
        step(8'h10, 0, 0, '0, '0, 6'd32, "R1 event with dma");
        step('0, 1, 0, '0, '0, 6'd0, "R3 read and drain");
        idle(6'd0, "R7 final");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule